// File: doc/BRIEF.md
# Nested Clock Power-Mode Controller

This block decides which clock domains of a processor-style subsystem are running. It drives four registered enables: the execution-unit clock, the bus clock, the main clock generator and the PLL power. There are four power levels. Each deeper level switches off every clock the shallower level switched off, and at least one more. Software selects a level with a one-cycle request pulse, but only while the system is fully on. An idle timer can also put the system to sleep on its own after a programmable number of quiet cycles.

In any reduced level, only the controller's small always-on logic keeps running. It watches the wake input. When a wake event arrives, it brings the clocks back one stage per cycle, in the reverse order of shutdown: clock generator first, then bus, then execution units. If the PLL was powered down in sleep, the controller first powers the PLL and then waits a programmable lock delay before the clock generator returns. A two-bit status output reports the current level.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During and after reset, all four enables are 1 and `mode_status` is 00 (full-on).
- R2: A request pulse with code 01 in full-on enters doze at the next edge: execution-unit enable 0, bus, generator and PLL enables 1, status 01.
- R3: A request pulse with code 10 in full-on enters nap at the next edge: execution-unit and bus enables 0, generator and PLL enables 1, status 10.
- R4: A request pulse with code 11 in full-on enters sleep at the next edge: execution-unit, bus and generator enables 0, status 11, and the PLL enable equals `pll_keep_cfg` as sampled at that edge.
- R5: A request is ignored outside full-on, and a request with code 00 changes nothing.
- R6: A wake event in doze, nap or sleep restores only the stopped enables, one per cycle, in the order generator, bus, execution unit. The status keeps its reduced code until the cycle in which the execution-unit enable returns, and then reads 00.
- R7: A wake event in sleep with the PLL off sets the PLL enable at the next edge. With lock delay D, the generator enable returns D+1 edges after that edge.
- R8: In full-on with `idle_limit` = N > 0, N consecutive edges with neither `activity` nor a request enter sleep as in R4. Any activity restarts the count, N = 0 disables the timer, and the timer does not run outside full-on.
- R9: When a request and the idle timeout fall on the same edge, the request wins.
- R10: The enables are always nested: execution-unit implies bus, bus implies generator, generator implies PLL.
- R11: A wake event in full-on, or while a restore sequence is in progress, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode: 00 full, 01 doze, 10 nap, 11 sleep |
| wake_evt | input | 1 | Wake event |
| activity | input | 1 | System activity, restarts the idle timer |
| pll_keep_cfg | input | 1 | 1 keeps the PLL running in sleep |
| idle_limit | input | IDLE_W | Idle cycles before automatic sleep, 0 disables |
| lock_delay | input | LOCK_W | Extra cycles to wait for PLL lock |
| exu_clk_en | output | 1 | Execution-unit clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| gen_clk_en | output | 1 | Clock-generator enable |
| pll_on | output | 1 | PLL power enable |
| mode_status | output | 2 | Current mode code, same encoding as `req_mode` |

## Verification
Two events can collide in full-on: a software request and the idle timer's expiry. The bench keeps `activity` low until the timer is one edge short of expiring. In that exact cycle it sends a doze request. The result is judged correct only if the next state is doze with its enable pattern, not sleep. A second collision, a wake event held high through a whole restore sequence, is judged by checking that the stage-by-stage enable pattern stays the same as with a single-cycle pulse.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_DOZE  = 2'b01,
    MODE_NAP   = 2'b10,
    MODE_SLEEP = 2'b11
  } mode_t;

  typedef enum logic [2:0] {
    ST_FULL,
    ST_DOZE,
    ST_NAP,
    ST_SLEEP,
    ST_LOCK,
    ST_UP_BUS,
    ST_UP_EXU
  } ctrl_state_t;
endpackage

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              active,
  input  logic [IDLE_W-1:0] limit,
  output logic              expire
);
  logic [IDLE_W-1:0] cnt;

  assign expire = enable && !active && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !enable || active || (limit == '0) || expire) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (enable && active) |=> (cnt == '0)) else $error("idle count not restarted"); // R8
endmodule

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOCK_W-1:0] load_val,
  output logic              done
);
  logic [LOCK_W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (!done) cnt <= cnt - 1'b1;
  end

  AST_LOCK_LOADED: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val))) else $error("lock count not loaded"); // R7
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              wake_evt,
  input  logic              activity,
  input  logic              pll_keep_cfg,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [LOCK_W-1:0] lock_delay,
  output logic              exu_clk_en,
  output logic              bus_clk_en,
  output logic              gen_clk_en,
  output logic              pll_on,
  output logic [1:0]        mode_status
);
  ctrl_state_t state;
  mode_t       status_q;
  logic        idle_expire;
  logic        lock_done;
  logic        in_full;
  logic        enter_sleep;
  logic        lock_load;

  assign in_full     = (state == ST_FULL);
  assign enter_sleep = in_full && ((req_valid && req_mode == MODE_SLEEP) ||
                                   (!req_valid && idle_expire));
  assign lock_load   = (state == ST_SLEEP) && wake_evt && !pll_on;
  assign mode_status = status_q;

  pmc_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .enable (in_full),
    .active (activity | req_valid),
    .limit  (idle_limit),
    .expire (idle_expire)
  );

  pmc_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .load     (lock_load),
    .load_val (lock_delay),
    .done     (lock_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FULL;
      status_q   <= MODE_FULL;
      exu_clk_en <= 1'b1;
      bus_clk_en <= 1'b1;
      gen_clk_en <= 1'b1;
      pll_on     <= 1'b1;
    end else if (enter_sleep) begin
      state      <= ST_SLEEP;
      status_q   <= MODE_SLEEP;
      exu_clk_en <= 1'b0;
      bus_clk_en <= 1'b0;
      gen_clk_en <= 1'b0;
      pll_on     <= pll_keep_cfg;
    end else begin
      case (state)
        ST_FULL: begin
          if (req_valid && req_mode == MODE_DOZE) begin
            state      <= ST_DOZE;
            status_q   <= MODE_DOZE;
            exu_clk_en <= 1'b0;
          end else if (req_valid && req_mode == MODE_NAP) begin
            state      <= ST_NAP;
            status_q   <= MODE_NAP;
            exu_clk_en <= 1'b0;
            bus_clk_en <= 1'b0;
          end
        end
        ST_DOZE: begin
          if (wake_evt) begin
            state      <= ST_FULL;
            status_q   <= MODE_FULL;
            exu_clk_en <= 1'b1;
          end
        end
        ST_NAP: begin
          if (wake_evt) begin
            state      <= ST_UP_EXU;
            bus_clk_en <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_evt) begin
            if (pll_on) begin
              state      <= ST_UP_BUS;
              gen_clk_en <= 1'b1;
            end else begin
              state  <= ST_LOCK;
              pll_on <= 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (lock_done) begin
            state      <= ST_UP_BUS;
            gen_clk_en <= 1'b1;
          end
        end
        ST_UP_BUS: begin
          state      <= ST_UP_EXU;
          bus_clk_en <= 1'b1;
        end
        ST_UP_EXU: begin
          state      <= ST_FULL;
          status_q   <= MODE_FULL;
          exu_clk_en <= 1'b1;
        end
        default: state <= ST_FULL;
      endcase
    end
  end

  AST_NESTED_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (!exu_clk_en || bus_clk_en) && (!bus_clk_en || gen_clk_en) && (!gen_clk_en || pll_on))
    else $error("enables not nested"); // R10
  AST_STATUS_MATCHES_EXU: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'b00) == exu_clk_en) else $error("status and exu enable disagree"); // R6
  AST_BUS_AFTER_GEN: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_clk_en) |-> $past(gen_clk_en)) else $error("bus restored before generator"); // R6
  AST_EXU_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(exu_clk_en) |-> $past(bus_clk_en)) else $error("exu restored before bus"); // R6
  AST_DOZE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'b00 && req_valid && req_mode == 2'b01) |=>
    (mode_status == 2'b01 && !exu_clk_en && bus_clk_en && gen_clk_en)) else $error("doze entry"); // R2
  AST_SLEEP_PLL: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'b00 && req_valid && req_mode == 2'b11) |=>
    (mode_status == 2'b11 && !gen_clk_en && pll_on == $past(pll_keep_cfg))) else $error("sleep entry"); // R4
  AST_LOCK_HOLDS_GEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !lock_done) |=> !gen_clk_en) else $error("generator before lock"); // R7
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic        wake_evt = 1'b0;
  logic        activity = 1'b1;
  logic        pll_keep_cfg = 1'b1;
  logic [15:0] idle_limit = '0;
  logic [7:0]  lock_delay = 8'd3;
  logic        exu_clk_en, bus_clk_en, gen_clk_en, pll_on;
  logic [1:0]  mode_status;

  // observed vector: {pll, gen, bus, exu, status}
  localparam logic [5:0] V_FULL   = 6'b111100;
  localparam logic [5:0] V_DOZE   = 6'b111001;
  localparam logic [5:0] V_NAP    = 6'b110010;
  localparam logic [5:0] V_SLPK   = 6'b100011;
  localparam logic [5:0] V_SLPO   = 6'b000011;
  localparam logic [5:0] V_UPGEN  = 6'b110011;
  localparam logic [5:0] V_UPBUS  = 6'b111011;

  typedef struct {
    int         cyc;
    logic [5:0] v;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .wake_evt(wake_evt), .activity(activity), .pll_keep_cfg(pll_keep_cfg),
    .idle_limit(idle_limit), .lock_delay(lock_delay),
    .exu_clk_en(exu_clk_en), .bus_clk_en(bus_clk_en), .gen_clk_en(gen_clk_en),
    .pll_on(pll_on), .mode_status(mode_status)
  );

  // monitor: pops the expected items due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [5:0] act;
      e   = q.pop_front();
      act = {pll_on, gen_clk_en, bus_clk_en, exu_clk_en, mode_status};
      total++;
      if (act !== e.v || e.cyc != cyc) begin
        bad++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b", e.tag, cyc, act, e.v);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_v(input int d, input logic [5:0] v, input string tag);
    exp_t e;
    e.cyc = cyc + d;
    e.v   = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic request(input logic [1:0] m, input logic [5:0] v, input string tag);
    req_valid = 1'b1;
    req_mode  = m;
    expect_v(1, v, tag);
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    tick();
    tick();
    expect_v(1, V_FULL, "R1");
    tick();
    rst = 1'b0;
    expect_v(1, V_FULL, "R1");
    tick();

    // doze, ignored request, wake
    request(2'b01, V_DOZE, "R2");
    request(2'b11, V_DOZE, "R5");
    wake_evt = 1'b1;
    expect_v(1, V_FULL, "R6");
    tick();
    wake_evt = 1'b0;

    // nap and two-step restore
    request(2'b10, V_NAP, "R3");
    tick();
    wake_evt = 1'b1;
    expect_v(1, 6'b111010, "R6");
    expect_v(2, V_FULL, "R6");
    tick();
    wake_evt = 1'b0;
    tick();

    // sleep with PLL kept; wake held through restore (R11)
    pll_keep_cfg = 1'b1;
    request(2'b11, V_SLPK, "R4");
    tick();
    wake_evt = 1'b1;
    expect_v(1, V_UPGEN, "R6");
    expect_v(2, V_UPBUS, "R11");
    expect_v(3, V_FULL, "R11");
    tick(); tick(); tick();
    wake_evt = 1'b0;
    tick();

    // sleep with PLL off, lock delay 3
    pll_keep_cfg = 1'b0;
    request(2'b11, V_SLPO, "R4");
    tick();
    wake_evt = 1'b1;
    expect_v(1, V_SLPK, "R7");
    expect_v(4, V_SLPK, "R7");
    expect_v(5, V_UPGEN, "R7");
    expect_v(6, V_UPBUS, "R6");
    expect_v(7, V_FULL, "R6");
    tick();
    wake_evt = 1'b0;
    repeat (8) tick();

    // lock delay 0
    lock_delay = 8'd0;
    request(2'b11, V_SLPO, "R4");
    wake_evt = 1'b1;
    expect_v(1, V_SLPK, "R7");
    expect_v(2, V_UPGEN, "R7");
    expect_v(4, V_FULL, "R7");
    tick();
    wake_evt = 1'b0;
    repeat (5) tick();

    // null request and wake in full-on
    request(2'b00, V_FULL, "R5");
    wake_evt = 1'b1;
    expect_v(1, V_FULL, "R11");
    tick();
    wake_evt = 1'b0;

    // idle timeout with restart
    pll_keep_cfg = 1'b1;
    idle_limit = 16'd5;
    tick();
    activity = 1'b0;
    expect_v(3, V_FULL, "R8");
    tick(); tick(); tick();
    activity = 1'b1;
    tick();
    activity = 1'b0;
    expect_v(4, V_FULL, "R8");
    expect_v(5, V_SLPK, "R8");
    repeat (5) tick();
    activity = 1'b1;
    wake_evt = 1'b1;
    expect_v(3, V_FULL, "R8");
    tick();
    wake_evt = 1'b0;
    repeat (3) tick();

    // request collides with timeout
    activity = 1'b0;
    repeat (4) tick();
    request(2'b01, V_DOZE, "R9");
    expect_v(10, V_DOZE, "R8");
    repeat (10) tick();
    activity = 1'b1;
    wake_evt = 1'b1;
    expect_v(1, V_FULL, "R9");
    tick();
    wake_evt = 1'b0;

    // timer disabled by limit 0
    idle_limit = '0;
    tick();
    activity = 1'b0;
    expect_v(20, V_FULL, "R8");
    repeat (22) tick();

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    int n;
    for (n = 0; n < 5000 && !done; n++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=done", n);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule